// File: doc/BRIEF.md
# Multisample Interval Timing Generator

This block sequences one frame of a time-domain image sensor whose pixels compare a discharging photodiode against a reference and latch the result on a comparator strobe. A start request begins a frame. The block first drives a pixel reset pulse for a fixed number of cycles. That pulse returns every photodiode to its starting voltage and clears every latched comparison flag. Integration then begins, and the block issues comparator strobes across a window of programmable length. Each strobe carries a sample code. The first strobe whose latched result shows a crossing therefore identifies the crossing time.

The spacing between strobes is chosen per frame. Uniform spacing divides the window evenly into 2^N slots. Logarithmic spacing doubles the interval after every K strobes, so early samples are dense and late ones sparse. Mixed spacing stays uniform for the first half of the codes and then switches to doubling. The non-uniform schedules let a short code cover a wide range of light levels. A one-cycle frame-done pulse marks the end of the frame. The frame ends at the last code or when the window runs out, whichever comes first.

Top module: `msamp_timing_gen`

## Requirements
- R1: After reset, pix_rst_o, cmp_strobe_o and frame_done_o are low and sample_code_o is 0.
- R2: A start accepted while idle makes pix_rst_o high for exactly RST_CYC cycles, from the cycle after the start edge. Integration starts in the cycle after that. No strobe occurs while pix_rst_o is high.
- R3: cmp_strobe_o is high for one cycle per sample. During each strobe, sample_code_o shows that sample's code: 0 for the first strobe of a frame, then one more for each following strobe.
- R4: With mode_i = 0 (uniform), the interval is B = max(1, floor(L / 2^N)) cycles, where L is int_len_i and N is the code width. The first strobe falls in integration cycle B-1 (counting from 0), and each later strobe follows the previous one by B cycles.
- R5: With mode_i = 1 (logarithmic), the interval starts at B and doubles after every K-th strobe, where K is grp_k_i and K = 0 acts as 1. The interval saturates at all ones and never shrinks within a frame.
- R6: With mode_i = 2 (mixed), the interval stays B for the first 2^(N-1) strobes. From then on, the interval doubles after every K strobes, counting from strobe number 2^(N-1).
- R7: frame_done_o pulses for one cycle in the cycle after the strobe with code 2^N-1, or in the cycle after integration cycle L-1 (L = 0 acts as 1), whichever comes first. It never coincides with a strobe or a pixel reset.
- R8: A start request while a frame is in its reset or integration phase is ignored and does not restart or extend the frame.
- R9: code_bits_i below 4 is treated as 4 and above 12 as 12; mode_i = 3 behaves as uniform.
- R10: The sample code returns to 0 at the start of every frame's integration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame start request, sampled while idle |
| mode_i | input | 2 | Schedule: 0 uniform, 1 logarithmic, 2 mixed, 3 uniform |
| int_len_i | input | LEN_W | Integration window in clock cycles |
| code_bits_i | input | NB_W | Code width N (clamped to 4..12) |
| grp_k_i | input | K_W | Strobes per doubling step (0 acts as 1) |
| pix_rst_o | output | 1 | Pixel reset pulse |
| cmp_strobe_o | output | 1 | Comparator sampling strobe |
| sample_code_o | output | CODE_W | Code of the current sample |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong interval register or group count shows up at the first strobe that lands in the wrong cycle. For logarithmic frames this is within K strobes of the fault, so every strobe cycle is compared exactly. A stale code or a missed wrap of the group counter shows up as a code mismatch on the next strobe. A broken end condition shows up as a done pulse one or more cycles away from the predicted last-strobe or expiry cycle. A phase machine that accepts start mid-frame shows up as a second reset pulse or a shifted strobe train within a few cycles.

// File: rtl/msamp_pkg.sv
package msamp_pkg;
  typedef enum logic [1:0] {
    SCHED_UNI = 2'd0,
    SCHED_LOG = 2'd1,
    SCHED_MIX = 2'd2,
    SCHED_ALT = 2'd3
  } sched_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PRST  = 2'd1,
    PH_INTEG = 2'd2
  } phase_e;
endpackage

// File: rtl/msamp_seq.sv
module msamp_seq
  import msamp_pkg::*;
#(
  parameter int LEN_W   = 24,
  parameter int RST_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             last_hit_i,
  output phase_e           phase_o,
  output logic             take_o,
  output logic             load_o,
  output logic             expire_o,
  output logic             done_o
);
  localparam int RC_W = (RST_CYC < 2) ? 1 : $clog2(RST_CYC);

  phase_e           ph_q;
  logic [RC_W-1:0]  rc_q;
  logic [LEN_W-1:0] el_q;
  logic             done_q;
  logic [LEN_W:0]   el_next;

  assign el_next  = {1'b0, el_q} + {{LEN_W{1'b0}}, 1'b1};
  assign take_o   = (ph_q == PH_IDLE) && start_i;
  assign load_o   = (ph_q == PH_PRST) && (rc_q == RC_W'(RST_CYC - 1));
  assign expire_o = (ph_q == PH_INTEG) && (el_next >= {1'b0, len_i});
  assign phase_o  = ph_q;
  assign done_o   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      rc_q   <= '0;
      el_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (start_i) begin
            ph_q <= PH_PRST;
            rc_q <= '0;
          end
        end
        PH_PRST: begin
          rc_q <= rc_q + RC_W'(1);
          if (load_o) begin
            ph_q <= PH_INTEG;
            el_q <= '0;
          end
        end
        PH_INTEG: begin
          el_q <= el_q + LEN_W'(1);
          if (expire_o || last_hit_i) begin
            ph_q   <= PH_IDLE;
            done_q <= 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msamp_sched.sv
module msamp_sched
  import msamp_pkg::*;
#(
  parameter int LEN_W  = 24,
  parameter int CODE_W = 12,
  parameter int K_W    = 4,
  parameter int NB_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  input  sched_e            mode_i,
  input  logic [NB_W-1:0]   nbits_i,
  input  logic [K_W-1:0]    grp_k_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [CODE_W-1:0] cnt_i,
  output logic [LEN_W-1:0]  iv_cur_o,
  output logic [LEN_W-1:0]  iv_reload_o
);
  function automatic logic [LEN_W-1:0] base_iv(input logic [LEN_W-1:0] len,
                                               input logic [NB_W-1:0] n);
    logic [LEN_W-1:0] sh;
    sh = len >> n;
    return (sh == '0) ? LEN_W'(1) : sh;
  endfunction

  function automatic logic [LEN_W-1:0] dbl_iv(input logic [LEN_W-1:0] iv);
    return iv[LEN_W-1] ? '1 : (iv << 1);
  endfunction

  logic [LEN_W-1:0] iv_q;
  logic [K_W-1:0]   grp_q;
  logic [K_W-1:0]   kk;
  logic [CODE_W:0]  seen;
  logic [CODE_W:0]  half;
  logic             in_log;
  logic             grp_wrap;
  logic [LEN_W-1:0] iv_nxt;
  logic [LEN_W-1:0] iv_base;

  assign kk       = (grp_k_i == '0) ? K_W'(1) : grp_k_i;
  assign seen     = {1'b0, cnt_i} + {{CODE_W{1'b0}}, 1'b1};
  assign half     = {{CODE_W{1'b0}}, 1'b1} << (nbits_i - NB_W'(1));
  assign in_log   = (mode_i == SCHED_LOG) || ((mode_i == SCHED_MIX) && (seen >= half));
  assign grp_wrap = ((grp_q + K_W'(1)) == kk);
  assign iv_nxt   = (in_log && grp_wrap) ? dbl_iv(iv_q) : iv_q;
  assign iv_base  = base_iv(len_i, nbits_i);

  assign iv_reload_o = load_i ? iv_base : iv_nxt;
  assign iv_cur_o    = iv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iv_q  <= LEN_W'(1);
      grp_q <= '0;
    end else if (load_i) begin
      iv_q  <= iv_base;
      grp_q <= '0;
    end else if (adv_i) begin
      iv_q <= iv_nxt;
      if (in_log) grp_q <= grp_wrap ? '0 : grp_q + K_W'(1);
    end
  end
endmodule

// File: rtl/msamp_strobe.sv
module msamp_strobe #(
  parameter int LEN_W  = 24,
  parameter int CODE_W = 12,
  parameter int NB_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              active_i,
  input  logic [NB_W-1:0]   nbits_i,
  input  logic [LEN_W-1:0]  reload_i,
  output logic              strobe_o,
  output logic              last_o,
  output logic [CODE_W-1:0] code_o
);
  logic [LEN_W-1:0]  tick_q;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W:0]   span;

  assign span     = {{CODE_W{1'b0}}, 1'b1} << nbits_i;
  assign strobe_o = active_i && (tick_q == LEN_W'(1));
  assign last_o   = strobe_o && ({1'b0, code_q} == (span - {{CODE_W{1'b0}}, 1'b1}));
  assign code_o   = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= LEN_W'(1);
      code_q <= '0;
    end else if (load_i) begin
      tick_q <= reload_i;
      code_q <= '0;
    end else if (strobe_o) begin
      tick_q <= reload_i;
      if (!last_o) code_q <= code_q + CODE_W'(1);
    end else if (active_i) begin
      tick_q <= tick_q - LEN_W'(1);
    end
  end
endmodule

// File: rtl/msamp_timing_gen.sv
module msamp_timing_gen
  import msamp_pkg::*;
#(
  parameter int LEN_W   = 24,
  parameter int CODE_W  = 12,
  parameter int N_MIN   = 4,
  parameter int K_W     = 4,
  parameter int RST_CYC = 4,
  parameter int NB_W    = $clog2(CODE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [LEN_W-1:0]  int_len_i,
  input  logic [NB_W-1:0]   code_bits_i,
  input  logic [K_W-1:0]    grp_k_i,
  output logic              pix_rst_o,
  output logic              cmp_strobe_o,
  output logic [CODE_W-1:0] sample_code_o,
  output logic              frame_done_o
);
  function automatic logic [NB_W-1:0] clamp_n(input logic [NB_W-1:0] v);
    if (v < NB_W'(N_MIN)) return NB_W'(N_MIN);
    if (v > NB_W'(CODE_W)) return NB_W'(CODE_W);
    return v;
  endfunction

  // latched frame configuration
  sched_e           mode_q;
  logic [LEN_W-1:0] len_q;
  logic [NB_W-1:0]  nb_q;
  logic [K_W-1:0]   k_q;

  // named internal events
  phase_e           phase;
  logic             take;
  logic             load;
  logic             expire;
  logic             strobe;
  logic             last_hit;
  logic [LEN_W-1:0] iv_cur;
  logic [LEN_W-1:0] iv_reload;
  logic [CODE_W-1:0] code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SCHED_UNI;
      len_q  <= '0;
      nb_q   <= NB_W'(N_MIN);
      k_q    <= '0;
    end else if (take) begin
      mode_q <= sched_e'(mode_i);
      len_q  <= int_len_i;
      nb_q   <= clamp_n(code_bits_i);
      k_q    <= grp_k_i;
    end
  end

  msamp_seq #(.LEN_W(LEN_W), .RST_CYC(RST_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_q),
    .last_hit_i(last_hit), .phase_o(phase), .take_o(take), .load_o(load),
    .expire_o(expire), .done_o(frame_done_o)
  );

  msamp_sched #(.LEN_W(LEN_W), .CODE_W(CODE_W), .K_W(K_W), .NB_W(NB_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .load_i(load), .adv_i(strobe), .mode_i(mode_q),
    .nbits_i(nb_q), .grp_k_i(k_q), .len_i(len_q), .cnt_i(code),
    .iv_cur_o(iv_cur), .iv_reload_o(iv_reload)
  );

  msamp_strobe #(.LEN_W(LEN_W), .CODE_W(CODE_W), .NB_W(NB_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .load_i(load), .active_i(phase == PH_INTEG),
    .nbits_i(nb_q), .reload_i(iv_reload), .strobe_o(strobe),
    .last_o(last_hit), .code_o(code)
  );

  assign pix_rst_o     = (phase == PH_PRST);
  assign cmp_strobe_o  = strobe;
  assign sample_code_o = code;
endmodule

// File: rtl/msamp_chk.sv
module msamp_chk #(
  parameter int LEN_W  = 24,
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              pix_rst_o,
  input logic              cmp_strobe_o,
  input logic [CODE_W-1:0] sample_code_o,
  input logic              frame_done_o,
  input logic [LEN_W-1:0]  iv_cur
);
  // R2
  no_strobe_in_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rst_o |-> !cmp_strobe_o);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);
  // R7
  done_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> (!cmp_strobe_o && !pix_rst_o));
  // R3
  code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_strobe_o |=> ((sample_code_o == $past(sample_code_o) + 1'b1) || frame_done_o));
  // R5
  iv_no_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_strobe_o |=> (iv_cur >= $past(iv_cur)));
  // R10
  code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pix_rst_o) |-> (sample_code_o == '0));
  // R8
  rst_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_rst_o) |-> $past(start_i));
endmodule

bind msamp_timing_gen msamp_chk #(.LEN_W(LEN_W), .CODE_W(CODE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .pix_rst_o(pix_rst_o),
  .cmp_strobe_o(cmp_strobe_o), .sample_code_o(sample_code_o),
  .frame_done_o(frame_done_o), .iv_cur(iv_cur)
);

// File: tb/test_msamp_timing_gen.sv
module test_msamp_timing_gen;
  localparam int LEN_W = 24;
  localparam int CODE_W = 12;
  localparam int K_W = 4;
  localparam int RST_CYC = 4;
  localparam int NB_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic [LEN_W-1:0] int_len_i = '0;
  logic [NB_W-1:0] code_bits_i = 4'd4;
  logic [K_W-1:0] grp_k_i = '0;
  logic pix_rst_o, cmp_strobe_o, frame_done_o;
  logic [CODE_W-1:0] sample_code_o;

  msamp_timing_gen #(.LEN_W(LEN_W), .CODE_W(CODE_W), .K_W(K_W), .RST_CYC(RST_CYC)) i_msamp_timing_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .int_len_i(int_len_i),
    .code_bits_i(code_bits_i), .grp_k_i(grp_k_i), .pix_rst_o(pix_rst_o),
    .cmp_strobe_o(cmp_strobe_o), .sample_code_o(sample_code_o), .frame_done_o(frame_done_o)
  );

  always #2 clk = ~clk;

  typedef struct { longint cyc; bit is_done; longint code; } ev_t;
  ev_t exp_q[$];
  int checks = 0;
  int failures = 0;
  longint cyc = 0;
  bit running = 1'b0;
  string cur_req = "R4";

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // reference schedule built from the requirements
  task automatic build(input int mode, input longint len, input int nb, input int k);
    longint n, iv, total, half, kk, prev, t, s, g, term, eff;
    bit all_done, in_log;
    n = (nb < 4) ? 4 : ((nb > 12) ? 12 : nb);
    eff = (len == 0) ? 1 : len;
    iv = len >> n; if (iv == 0) iv = 1;
    total = 64'd1 << n; half = total / 2;
    kk = (k == 0) ? 1 : k;
    prev = -1; g = 0; all_done = 1'b1;
    for (longint j = 0; j < total; j++) begin
      t = prev + iv;
      if (t > eff - 1) begin all_done = 1'b0; break; end
      exp_q.push_back('{cyc: RST_CYC + 1 + t, is_done: 1'b0, code: j});
      prev = t;
      s = j + 1;
      in_log = (mode == 1) || (mode == 2 && s >= half);
      if (in_log) begin
        g++;
        if (g == kk) begin
          g = 0;
          iv = (iv >= (64'd1 << (LEN_W-1))) ? ((64'd1 << LEN_W) - 1) : iv * 2;
        end
      end
    end
    term = all_done ? prev : eff - 1;
    exp_q.push_back('{cyc: RST_CYC + 1 + term + 1, is_done: 1'b1, code: 0});
  endtask

  // driver: push expectations, launch a frame, optionally poke start mid-frame
  task automatic run_frame(input int mode, input longint len, input int nb, input int k,
                           input string req, input bit poke);
    cur_req = req;
    build(mode, len, nb, k);
    @(negedge clk);
    mode_i = mode[1:0]; int_len_i = len[LEN_W-1:0];
    code_bits_i = nb[NB_W-1:0]; grp_k_i = k[K_W-1:0];
    start_i = 1'b1; cyc = 0; running = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    mode_i = 2'd3; int_len_i = 24'd7; code_bits_i = 4'd9; grp_k_i = 4'd5;
    if (poke) begin
      @(negedge clk); start_i = 1'b1;   // during pixel reset (R8)
      @(negedge clk); start_i = 1'b0;
      repeat (RST_CYC + 3) @(negedge clk);
      start_i = 1'b1;                   // during integration (R8)
      @(negedge clk); start_i = 1'b0;
    end
    wait (running == 1'b0);
    repeat (3) @(negedge clk);
    chk(pix_rst_o == 1'b0, "R8", pix_rst_o, 0);
  endtask

  // monitor: compares outputs with the scoreboard queue 1 ns after each edge
  always @(posedge clk) begin
    #1;
    if (running) begin
      cyc++;
      if (cyc == RST_CYC) chk(pix_rst_o == 1'b1, "R2", pix_rst_o, 1);
      if (cyc == RST_CYC + 1) chk(pix_rst_o == 1'b0, "R2", pix_rst_o, 0);
      if (exp_q.size() > 0 && !exp_q[0].is_done && exp_q[0].cyc == cyc) begin
        chk(cmp_strobe_o == 1'b1, cur_req, cmp_strobe_o, 1);
        chk(sample_code_o == exp_q[0].code[CODE_W-1:0], "R3", sample_code_o, exp_q[0].code);
        void'(exp_q.pop_front());
      end else if (cmp_strobe_o) begin
        chk(1'b0, cur_req, 1, 0);
      end
      if (exp_q.size() > 0 && exp_q[0].is_done && exp_q[0].cyc == cyc) begin
        chk(frame_done_o == 1'b1, "R7", frame_done_o, 1);
        void'(exp_q.pop_front());
        running = 1'b0;
      end else if (frame_done_o) begin
        chk(1'b0, "R7", 1, 0);
      end
    end
  end

  initial begin
    for (int w = 0; w < 190000; w++) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pix_rst_o == 0 && cmp_strobe_o == 0 && frame_done_o == 0, "R1", pix_rst_o, 0);
    chk(sample_code_o == 0, "R1", sample_code_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(pix_rst_o == 0 && frame_done_o == 0, "R1", pix_rst_o, 0);

    run_frame(0, 256, 4, 0, "R4", 1'b0);    // exact fit: last code at window end
    run_frame(0, 1000, 5, 0, "R4", 1'b1);   // remainder, last code before expiry; R8 pokes
    run_frame(1, 3000, 4, 2, "R5", 1'b0);   // doubling every 2, expiry ends frame
    run_frame(1, 600, 4, 0, "R5", 1'b0);    // K=0 acts as 1
    run_frame(2, 2000, 5, 3, "R6", 1'b0);   // uniform half then doubling
    run_frame(2, 700, 4, 1, "R6", 1'b1);
    run_frame(0, 64, 2, 0, "R9", 1'b0);     // N below range -> 4
    run_frame(0, 8192, 15, 0, "R9", 1'b0);  // N above range -> 12
    run_frame(3, 300, 4, 0, "R9", 1'b0);    // mode 3 acts as uniform
    run_frame(0, 10, 4, 0, "R7", 1'b0);     // window shorter than code count
    run_frame(0, 0, 4, 0, "R7", 1'b0);      // zero window acts as one cycle
    run_frame(1, 200, 6, 3, "R10", 1'b0);   // code restarts at 0 (R10)

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule